// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (clock and data, SMBus-style signalling) that lets a host read and write a small bank of configuration bytes. A fast system clock oversamples both bus lines through two-flop synchronizers. Start, repeated-start and stop conditions are detected from the synchronized lines. The slave pulls the data line low through an open-drain enable output and never drives it high.

The command byte that follows the write address selects the access type. With its top bit set, the low seven bits are a register offset, and the access reads or writes exactly that one byte. With its top bit clear, the access is a block transfer that always begins at register 0. A block write carries a byte count ahead of its data. A block read returns the bank size as a count, then the registers in ascending order. The bank contents appear on a flat parallel output for the rest of the chip. Register 0 holds a spread-mode code in bits 7:5 and a frequency-select code in bits 4:0. Register 1 holds one output-enable bit per clock output.

Top module: `smb_regslave`

## Requirements
- R1: After reset, register 1 reads 0xFF and all other registers read 0x00. `reg_q[8*k+7:8*k]` carries register k, and `sda_oe` is 0.
- R2: The slave acknowledges address byte 0xD2 (7-bit address 0x69 with a write bit of 0) and address byte 0xD3 (the same address with a read bit of 1). It acknowledges by driving `sda_oe` high during the ninth clock of the byte.
- R3: The slave does not acknowledge any other address byte. It ignores all later bytes until the next start condition, and the registers are left unchanged.
- R4: In a byte write, the command byte has bit 7 set and carries the offset in bits 6:0. The slave acknowledges the address, the command and the data byte, then loads the data into the register at that offset.
- R5: A byte read is a command with bit 7 set, then a repeated start, then address 0xD3. The slave returns the register at that offset, MSB first, and the host ends the read with a NACK.
- R6: In a block write, the command byte is 0x00 and is followed by a byte count. The data bytes then fill the registers starting at register 0, one per register in ascending order. Each byte arrives MSB first and is acknowledged.
- R7: In a block write, data bytes beyond the byte count, or beyond the 8-register bank, are acknowledged but discarded.
- R8: If a block write ends with a stop after any complete byte, the registers already written keep their new values and the others are unchanged.
- R9: A block read is command 0x00, a repeated start, then address 0xD3. The slave sends the count 0x08 and then registers 0 to 7. A host NACK ends the transmission, and the slave then releases the data line.
- R10: A byte write to an offset of 8 or more is acknowledged and discarded. A byte read from such an offset returns 0x00.
- R11: A start or stop condition inside a byte aborts the transaction in progress without writing a register. After a start, the slave decodes the next byte as a fresh address.
- R12: `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_q | output | 8*NREG | Register bank contents; register k sits in bits 8k+7:8k |

## Verification
The embedded properties check several behaviours on every cycle. The data-line enable never toggles while the clock is high. A mismatched address is never acknowledged. The register bank changes only while a data byte is being received. A stop always returns the slave to idle with the line released. A block read always opens with the bank-size count. The scenarios in the bench are needed for the rest, because only a full transaction shows it. These are the byte order and MSB-first packing of block data, the counted discard of surplus bytes, and partial blocks that end early. They also cover the zero value returned for out-of-bank reads and recovery after a byte is cut short by a start or a stop. A behavioural register model checks each of these against the parallel outputs on every idle clock.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  parameter logic [7:0] R1_RESET = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] reg_q
);

  localparam int         IW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [6:0] NREG7 = 7'(NREG);
  localparam logic [7:0] NREG8 = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDAT, S_TX} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic [7:0] sh, txsh, left;
  logic [3:0] bitc;
  logic       in_ack, hack, blk;
  logic [6:0] ptr;
  logic [7:0] regs [NREG];

  wire scl       = scl_sy[1];
  wire sda       = sda_sy[1];
  wire scl_rise  = scl & ~scl_p;
  wire scl_fall  = ~scl & scl_p;
  wire start_det = scl & scl_p & sda_p & ~sda;
  wire stop_det  = scl & scl_p & ~sda_p & sda;
  wire byte_done = scl_fall & ~in_ack & (bitc == 4'd8);
  wire addr_hit  = (sh[7:1] == DEV_ADDR);
  wire [6:0] ptr_inc = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
  wire [7:0] rd_ptr  = (ptr < NREG7) ? regs[ptr[IW-1:0]] : 8'h00;
  wire wr_en = (st == S_WDAT) & byte_done & (left != 8'd0) & (ptr < NREG7);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_q[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == 1) ? R1_RESET : 8'h00;
    end else if (wr_en) begin
      regs[ptr[IW-1:0]] <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b00; sda_sy <= 2'b00; scl_p <= 1'b0; sda_p <= 1'b0;
      st <= S_IDLE; sh <= 8'h00; txsh <= 8'h00; left <= 8'h00;
      bitc <= 4'd0; in_ack <= 1'b0; hack <= 1'b0; blk <= 1'b1;
      ptr <= 7'd0; sda_oe <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl;
      sda_p  <= sda;
      if (start_det) begin
        st <= S_ADDR; bitc <= 4'd0; in_ack <= 1'b0; hack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; bitc <= 4'd0; in_ack <= 1'b0; hack <= 1'b0; sda_oe <= 1'b0;
      end else if (st == S_TX) begin
        if (in_ack | hack) begin
          if (scl_rise & hack) begin
            if (sda) st <= S_IDLE;
            else begin txsh <= rd_ptr; ptr <= ptr_inc; end
          end
          if (scl_fall) begin
            in_ack <= 1'b0; hack <= 1'b0; bitc <= 4'd0; sda_oe <= ~txsh[7];
          end
        end else begin
          if (scl_rise) bitc <= bitc + 4'd1;
          if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b0; hack <= 1'b1;
            end else begin
              txsh <= {txsh[6:0], 1'b0}; sda_oe <= ~txsh[6];
            end
          end
        end
      end else if (st != S_IDLE) begin
        if (!in_ack) begin
          if (scl_rise) begin
            sh <= {sh[6:0], sda}; bitc <= bitc + 4'd1;
          end
          if (byte_done) begin
            in_ack <= 1'b1;
            sda_oe <= 1'b1;
            case (st)
              S_ADDR: begin
                if (!addr_hit) begin
                  sda_oe <= 1'b0; st <= S_IDLE;
                end else if (sh[0]) begin
                  st <= S_TX;
                  if (blk) txsh <= NREG8;
                  else begin txsh <= rd_ptr; ptr <= ptr_inc; end
                end else begin
                  st <= S_CMD;
                end
              end
              S_CMD: begin
                blk  <= ~sh[7];
                ptr  <= sh[7] ? sh[6:0] : 7'd0;
                left <= sh[7] ? 8'd1 : 8'd0;
                st   <= sh[7] ? S_WDAT : S_CNT;
              end
              S_CNT: begin
                left <= sh; st <= S_WDAT;
              end
              S_WDAT: begin
                if (left != 8'd0) left <= left - 8'd1;
                ptr <= ptr_inc;
              end
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          in_ack <= 1'b0; bitc <= 4'd0; sda_oe <= 1'b0;
        end
      end
    end
  end

  // R12
  oe_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl));

  // R3
  no_ack_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && byte_done && !addr_hit) |=> !sda_oe);

  // R6
  reg_in_wdat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q != $past(reg_q)) |-> ($past(st) == S_WDAT));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));

  // R11
  bitc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitc <= 4'd8);

  // R9
  blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_ADDR && st == S_TX && blk) |-> (txsh == NREG8));

endmodule

// File: tb/sim_smb_regslave.sv
module sim_smb_regslave;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1;
  logic sda_oe;
  logic [63:0] reg_q;
  wire sda_line = hsda & ~sda_oe;

  always #5 clk = ~clk;

  smb_regslave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                   .sda_oe(sda_oe), .reg_q(reg_q));

  int total = 0, bad = 0;
  bit cmp_en = 1'b0;
  logic [7:0] exp_r [8];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = exp_r[i];
    return f;
  endfunction

  always @(negedge clk) if (cmp_en) begin
    chk(reg_q == exp_flat(), "R6 model regs", reg_q, exp_flat());
    chk(sda_oe == 1'b0, "R12 idle release", {63'd0, sda_oe}, 64'd0);
  end

  task automatic q(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    hsda = 1'b1; q(); scl = 1'b1; q(); hsda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_rstart();
    hsda = 1'b1; q(); scl = 1'b1; q(); hsda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    hsda = 1'b0; q(); scl = 1'b1; q(); hsda = 1'b1; q(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hsda = b[i]; q(); scl = 1'b1; q(2); scl = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    hsda = 1'b1; q(); scl = 1'b1; q();
    ack = (sda_line == 1'b0);
    q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit host_ack);
    hsda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
    end
    q(); hsda = ~host_ack; q(); scl = 1'b1; q(2); scl = 1'b0; q(); hsda = 1'b1;
  endtask

  task automatic idle_cmp();
    cmp_en = 1'b1; repeat (20) @(negedge clk); cmp_en = 1'b0;
  endtask

  task automatic byte_wr(input logic [6:0] off, input logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write addr ack", {63'd0, a}, 64'd1);
    send_byte({1'b1, off}, a); chk(a, "R4 cmd ack", {63'd0, a}, 64'd1);
    send_byte(d, a); chk(a, "R4 R10 data ack", {63'd0, a}, 64'd1);
    bus_stop();
    if (off < 7'd8) exp_r[off[2:0]] = d;
    idle_cmp();
  endtask

  task automatic byte_rd(input logic [6:0] off);
    bit a;
    logic [7:0] d, ex;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write addr ack", {63'd0, a}, 64'd1);
    send_byte({1'b1, off}, a); chk(a, "R5 cmd ack", {63'd0, a}, 64'd1);
    bus_rstart();
    send_byte(8'hD3, a); chk(a, "R2 read addr ack", {63'd0, a}, 64'd1);
    recv_byte(d, 1'b0);
    bus_stop();
    ex = (off < 7'd8) ? exp_r[off[2:0]] : 8'h00;
    chk(d == ex, (off < 7'd8) ? "R5 byte read data" : "R10 out-of-bank read", {56'd0, d}, {56'd0, ex});
    idle_cmp();
  endtask

  task automatic blk_wr(input logic [7:0] cnt, input int n, input logic [7:0] base);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write addr ack", {63'd0, a}, 64'd1);
    send_byte(8'h00, a); chk(a, "R6 block cmd ack", {63'd0, a}, 64'd1);
    send_byte(cnt, a); chk(a, "R6 count ack", {63'd0, a}, 64'd1);
    for (int i = 0; i < n; i++) begin
      b = base ^ 8'(i * 19);
      send_byte(b, a); chk(a, "R7 block data ack", {63'd0, a}, 64'd1);
      if (i < int'(cnt) && i < 8) exp_r[i] = b;
    end
    bus_stop();
    idle_cmp();
  endtask

  task automatic blk_rd();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write addr ack", {63'd0, a}, 64'd1);
    send_byte(8'h00, a); chk(a, "R9 block cmd ack", {63'd0, a}, 64'd1);
    bus_rstart();
    send_byte(8'hD3, a); chk(a, "R2 read addr ack", {63'd0, a}, 64'd1);
    recv_byte(d, 1'b1); chk(d == 8'h08, "R9 block count", {56'd0, d}, 64'h08);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i != 7);
      chk(d == exp_r[i], "R9 block data", {56'd0, d}, {56'd0, exp_r[i]});
    end
    chk(sda_oe == 1'b0, "R9 release after NACK", {63'd0, sda_oe}, 64'd0);
    bus_stop();
    idle_cmp();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 8; i++) exp_r[i] = (i == 1) ? 8'hFF : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset defaults
    chk(reg_q == 64'h0000_0000_0000_FF00, "R1 reset regs", reg_q, 64'h0000_0000_0000_FF00);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", {63'd0, sda_oe}, 64'd0);
    idle_cmp();

    byte_wr(7'd3, 8'hA5);
    byte_rd(7'd3);
    byte_rd(7'd1);
    byte_wr(7'd0, 8'h6B);
    byte_rd(7'd0);

    blk_wr(8'd8, 8, 8'h11);
    blk_rd();
    blk_wr(8'd3, 5, 8'hA0);
    blk_wr(8'd10, 10, 8'hC3);
    blk_rd();
    // R8 early stop after two bytes of an eight-byte block
    blk_wr(8'd8, 2, 8'hE7);
    blk_rd();

    byte_wr(7'd9, 8'h5A);
    byte_rd(7'd9);
    byte_rd(7'd127);

    // R3 mismatched address
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R3 no ack bad addr", {63'd0, a}, 64'd0);
    send_byte(8'h82, a); chk(!a, "R3 ignored cmd", {63'd0, a}, 64'd0);
    send_byte(8'h3C, a); chk(!a, "R3 ignored data", {63'd0, a}, 64'd0);
    bus_stop();
    idle_cmp();

    // R11 stop inside a data byte
    bus_start();
    send_byte(8'hD2, a); chk(a, "R11 addr ack", {63'd0, a}, 64'd1);
    send_byte(8'h82, a); chk(a, "R11 cmd ack", {63'd0, a}, 64'd1);
    send_bits(8'hC3, 4);
    bus_stop();
    idle_cmp();
    byte_rd(7'd2);

    // R11 repeated start inside a byte restarts address decode
    bus_start();
    send_byte(8'hD2, a); chk(a, "R11 addr ack", {63'd0, a}, 64'd1);
    send_bits(8'h85, 3);
    bus_rstart();
    send_byte(8'hD2, a); chk(a, "R11 addr after restart", {63'd0, a}, 64'd1);
    send_byte(8'h82, a); chk(a, "R11 cmd after restart", {63'd0, a}, 64'd1);
    send_byte(8'h3C, a); chk(a, "R11 data after restart", {63'd0, a}, 64'd1);
    bus_stop();
    exp_r[2] = 8'h3C;
    idle_cmp();
    byte_rd(7'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule